// File: doc/BRIEF.md
# Masked Pattern-Match Trigger Unit

This block watches a 64-bit sample stream that arrives with a valid strobe. Each sample is compared against two masked patterns that are set up separately. A match on the first pattern raises a timestamp request, but only while timestamp insertion is switched on. A match on the second pattern raises a trigger pulse. A collection filter also marks which samples are captured. In continuous mode it captures every valid sample. In on-change mode it captures only samples that differ from the sample before.

Software configures the unit through a 32-bit register port with a word address. The port holds a control register (enable and collection mode), a timestamp-enable register and four banks of two words each: timestamp pattern, timestamp mask, trigger pattern and trigger mask. Every result comes from a register stage, so downstream logic sees single-cycle pulses that are aligned with the captured data.

Top module: `pmt_unit`

## Requirements
- R1: After reset all outputs are 0 and every register reads back as 0.
- R2: Register map with byte offsets. 0xA00 is control: bit 0 enables the unit, bit 1 selects on-change mode, and all other bits read as 0. 0xA04 bit 0 enables timestamping. Timestamp pattern is at 0xA08/0xA0C, timestamp mask at 0xA10/0xA14, trigger pattern at 0xA18/0xA1C and trigger mask at 0xA20/0xA24. Read data appears one cycle after the read strobe. Any other address, including misaligned ones, reads 0.
- R3: A mask bit of 1 compares the pattern bit at the same position, and a mask bit of 0 is don't-care, so an all-zero mask matches every sample. The first word of each bank (lower address) covers data bits [31:0], and the second word covers bits [63:32].
- R4: `trig_pulse` is 1 in the cycle after each valid sample that matches the trigger pattern under its mask. A non-matching sample or an idle cycle gives 0.
- R5: `ts_req` is 1 in the cycle after a valid sample that matches the timestamp pattern under its mask, and only while timestamping is enabled.
- R6: While the enable bit is 0, all of `cap_valid`, `trig_pulse` and `ts_req` stay 0.
- R7: In continuous mode (control bit 1 = 0), every valid sample gives `cap_valid`=1 one cycle later, with `cap_data` equal to the sample.
- R8: In on-change mode, a valid sample is captured only if it differs from the previous valid sample. The first valid sample after the enable bit was 0 always counts as changed.
- R9: Trigger and timestamp matching do not depend on the collection mode. A repeated sample in on-change mode still raises them.
- R10: A cycle with `in_valid`=0 produces no pulse and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| in_valid | input | 1 | Sample valid strobe |
| in_data | input | 64 | Sample data |
| cap_valid | output | 1 | Captured-sample strobe |
| cap_data | output | 64 | Captured sample |
| trig_pulse | output | 1 | Trigger pattern match pulse |
| ts_req | output | 1 | Timestamp request pulse |

## Verification
`cap_valid`, `cap_data`, `trig_pulse` and `ts_req` for a sample presented at one rising edge are all due right after that edge, with no further latency. Read data is due one edge after the read strobe. A register write changes how the next sample is judged. The bench drives each sample or access on a falling edge and compares against its own model on the next falling edge, so it always samples a settled value one register stage after the stimulus. Single-cycle pulse width is checked by following matching samples with idle cycles and expecting 0.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef struct packed {
    logic mode;    // 1: capture on change
    logic enable;
  } ctrl_t;

  localparam int CTRL_OFS  = 'hA00;
  localparam int TSEN_OFS  = 'hA04;
  localparam int BANK_BASE = 'hA08;
  localparam int NBANK     = 4;
  localparam int BK_TSP    = 0;
  localparam int BK_TSM    = 1;
  localparam int BK_TGP    = 2;
  localparam int BK_TGM    = 3;
endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output ctrl_t             ctrl,
  output logic              ts_en,
  output logic [DATA_W-1:0] ts_pat,
  output logic [DATA_W-1:0] ts_mask,
  output logic [DATA_W-1:0] tg_pat,
  output logic [DATA_W-1:0] tg_mask
);
  localparam int NW   = DATA_W / REG_W;
  localparam int STEP = REG_W / 8;

  function automatic logic [ADDR_W-1:0] word_addr(int bank, int w);
    return ADDR_W'(BANK_BASE + (bank * NW + w) * STEP);
  endfunction

  logic [REG_W-1:0] bank_q [NBANK][NW];
  logic [REG_W-1:0] rd_mux;
  logic             rd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      ts_en <= 1'b0;
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < NW; w++)
          bank_q[b][w] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(CTRL_OFS))
        ctrl <= '{mode: reg_wdata[1], enable: reg_wdata[0]};
      if (reg_addr == ADDR_W'(TSEN_OFS))
        ts_en <= reg_wdata[0];
      for (int b = 0; b < NBANK; b++)
        for (int w = 0; w < NW; w++)
          if (reg_addr == word_addr(b, w))
            bank_q[b][w] <= reg_wdata;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign ts_pat [w*REG_W +: REG_W] = bank_q[BK_TSP][w];
    assign ts_mask[w*REG_W +: REG_W] = bank_q[BK_TSM][w];
    assign tg_pat [w*REG_W +: REG_W] = bank_q[BK_TGP][w];
    assign tg_mask[w*REG_W +: REG_W] = bank_q[BK_TGM][w];
  end

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    if (reg_addr == ADDR_W'(CTRL_OFS)) begin
      rd_mux = REG_W'(ctrl);
      rd_hit = 1'b1;
    end
    if (reg_addr == ADDR_W'(TSEN_OFS)) begin
      rd_mux = REG_W'(ts_en);
      rd_hit = 1'b1;
    end
    for (int b = 0; b < NBANK; b++)
      for (int w = 0; w < NW; w++)
        if (reg_addr == word_addr(b, w)) begin
          rd_mux = bank_q[b][w];
          rd_hit = 1'b1;
        end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd && !rd_hit |=> reg_rdata == '0); // R2
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(CTRL_OFS) |=> reg_rdata[REG_W-1:2] == '0); // R2
endmodule

// File: rtl/pmt_match.sv
module pmt_match #(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);
  localparam int NW = DATA_W / REG_W;

  logic [NW-1:0] word_hit;

  for (genvar w = 0; w < NW; w++) begin : g_cmp
    assign word_hit[w] =
      ((data[w*REG_W +: REG_W] ^ pat[w*REG_W +: REG_W]) & mask[w*REG_W +: REG_W]) == '0;
  end

  assign hit = &word_hit;
endmodule

// File: rtl/pmt_collect.sv
module pmt_collect #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data
);
  logic              have_prev;
  logic [DATA_W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
      have_prev <= 1'b0;
      prev      <= '0;
    end else begin
      cap_valid <= 1'b0;
      if (!enable) begin
        have_prev <= 1'b0;
      end else if (in_valid) begin
        have_prev <= 1'b1;
        prev      <= in_data;
        if (!mode || !have_prev || in_data != prev) begin
          cap_valid <= 1'b1;
          cap_data  <= in_data;
        end
      end
    end
  end

  AST_CONT_CAPTURES_ALL: assert property (@(posedge clk) disable iff (rst)
    enable && !mode && in_valid |=> cap_valid && cap_data == $past(in_data)); // R7
  AST_REPEAT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    enable && mode && in_valid && have_prev && in_data == prev |=> !cap_valid); // R8
endmodule

// File: rtl/pmt_unit.sv
module pmt_unit
  import pmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data,
  output logic              trig_pulse,
  output logic              ts_req
);
  ctrl_t             ctrl;
  logic              ts_en;
  logic [DATA_W-1:0] ts_pat, ts_mask, tg_pat, tg_mask;
  logic              ts_hit, tg_hit;

  pmt_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .ts_en(ts_en), .ts_pat(ts_pat), .ts_mask(ts_mask),
    .tg_pat(tg_pat), .tg_mask(tg_mask)
  );

  pmt_match #(.DATA_W(DATA_W), .REG_W(REG_W)) u_ts_match (
    .data(in_data), .pat(ts_pat), .mask(ts_mask), .hit(ts_hit)
  );

  pmt_match #(.DATA_W(DATA_W), .REG_W(REG_W)) u_tg_match (
    .data(in_data), .pat(tg_pat), .mask(tg_mask), .hit(tg_hit)
  );

  pmt_collect #(.DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst(rst), .enable(ctrl.enable), .mode(ctrl.mode),
    .in_valid(in_valid), .in_data(in_data),
    .cap_valid(cap_valid), .cap_data(cap_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_pulse <= 1'b0;
      ts_req     <= 1'b0;
    end else begin
      trig_pulse <= in_valid && ctrl.enable && tg_hit;
      ts_req     <= in_valid && ctrl.enable && ts_en && ts_hit;
    end
  end

  AST_TRIG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctrl.enable && tg_hit |=> trig_pulse); // R4
  AST_TS_GATED: assert property (@(posedge clk) disable iff (rst)
    !ts_en |=> !ts_req); // R5
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !ctrl.enable |=> !(cap_valid || trig_pulse || ts_req)); // R6
  AST_TRIG_ANY_MODE: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctrl.enable && ctrl.mode && tg_hit |=> trig_pulse); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(cap_valid || trig_pulse || ts_req)); // R10
endmodule

// File: tb/pmt_unit_bench.sv
module pmt_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        cap_valid, trig_pulse, ts_req;
  logic [63:0] cap_data;

  int n_checks = 0;
  int n_errors = 0;

  logic        m_en = 0, m_mode = 0, m_tsen = 0, m_have = 0;
  logic [63:0] m_tsp = '0, m_tsm = '0, m_tgp = '0, m_tgm = '0, m_prev = '0;

  pmt_unit u_pmt_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_data(in_data),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .trig_pulse(trig_pulse), .ts_req(ts_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic masked_hit(logic [63:0] d, logic [63:0] p, logic [63:0] m);
    return ((d ^ p) & m) == 64'd0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      12'hA00: begin m_en = d[0]; m_mode = d[1]; if (!d[0]) m_have = 0; end
      12'hA04: m_tsen = d[0];
      12'hA08: m_tsp[31:0]  = d;
      12'hA0C: m_tsp[63:32] = d;
      12'hA10: m_tsm[31:0]  = d;
      12'hA14: m_tsm[63:32] = d;
      12'hA18: m_tgp[31:0]  = d;
      12'hA1C: m_tgp[63:32] = d;
      12'hA20: m_tgm[31:0]  = d;
      12'hA24: m_tgm[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(logic v, logic [63:0] d);
    logic ev, e_cap, e_tg, e_ts;
    string rq;
    @(negedge clk);
    in_valid = v; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    ev    = v && m_en;
    e_cap = ev && (!m_mode || !m_have || d != m_prev);
    e_tg  = ev && masked_hit(d, m_tgp, m_tgm);
    e_ts  = ev && m_tsen && masked_hit(d, m_tsp, m_tsm);
    rq = !v ? "R10" : !m_en ? "R6" : m_mode ? "R8" : "R7";
    check({rq, " cap_valid"}, 64'(cap_valid), 64'(e_cap));
    if (e_cap) check({rq, " cap_data"}, cap_data, d);
    rq = !v ? "R10" : !m_en ? "R6" : m_mode ? "R9" : "R4";
    check({rq, " trig_pulse"}, 64'(trig_pulse), 64'(e_tg));
    rq = !v ? "R10" : !m_en ? "R6" : "R5";
    check({rq, " ts_req"}, 64'(ts_req), 64'(e_ts));
    if (ev) begin m_have = 1; m_prev = d; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL R10: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cap_valid", 64'(cap_valid), 0);
    check("R1 trig_pulse", 64'(trig_pulse), 0);
    check("R1 ts_req", 64'(ts_req), 0);
    rst = 1'b0;
    for (int a = 'hA00; a <= 'hA24; a += 4) rd_check("R1 regs", 12'(a), 32'd0);

    // R3 all-zero mask matches everything
    wr(12'hA00, 32'h1);
    send(1, 64'h1234_5678_9ABC_DEF0);
    send(0, 64'h0);               // R4 pulse is one cycle
    send(1, 64'hFFFF_FFFF_FFFF_FFFF);

    // R3 high word covers bits 63:32
    wr(12'hA24, 32'h20);
    wr(12'hA1C, 32'h20);
    send(1, 64'h0000_0020_0000_0000);
    send(1, 64'h0000_0000_0000_0020);
    send(1, 64'hFFFF_FFFF_0000_0000);

    // R2 readback and unmapped
    rd_check("R2 trig pat hi", 12'hA1C, 32'h20);
    wr(12'hA00, 32'hFFFF_FFFD);
    rd_check("R2 ctrl upper bits", 12'hA00, 32'h1);
    rd_check("R2 unmapped", 12'hA28, 32'h0);
    rd_check("R2 misaligned", 12'hA1E, 32'h0);

    // R5 timestamp gating
    wr(12'hA10, 32'hFF);
    wr(12'hA08, 32'h5A);
    wr(12'hA04, 32'h1);
    send(1, 64'hABCD_0000_0000_005A);
    send(1, 64'h0000_0000_0000_005B);
    wr(12'hA04, 32'h0);
    send(1, 64'h0000_0000_0000_005A);
    wr(12'hA04, 32'h1);

    // R8 / R9 on-change mode
    wr(12'hA00, 32'h3);
    send(1, 64'h0000_0020_0000_005A);
    send(1, 64'h0000_0020_0000_005A);
    send(1, 64'h0000_0000_0000_0011);
    send(1, 64'h0000_0000_0000_0011);
    send(0, 64'h0000_0000_0000_0099);
    send(1, 64'h0000_0020_0000_005A);
    wr(12'hA00, 32'h0);
    wr(12'hA00, 32'h3);
    send(1, 64'h0000_0020_0000_005A); // first after enable counts as changed

    // R6 disabled
    wr(12'hA00, 32'h2);
    send(1, 64'h0000_0020_0000_005A);
    send(1, 64'h1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) begin
        int sel;
        logic [31:0] v;
        sel = $urandom % 10;
        v = $urandom;
        if (sel == 0) wr(12'hA00, {30'd0, v[1], ($urandom % 4 != 0)});
        else if (sel == 1) wr(12'hA04, v);
        else if ((sel - 2) % 4 == 1 || (sel - 2) % 4 == 3)
          wr(12'(('hA08) + (sel - 2) * 4), v & $urandom & $urandom);
        else wr(12'(('hA08) + (sel - 2) * 4), v);
      end else begin
        logic [63:0] d;
        int k;
        k = $urandom % 4;
        d = (k == 0) ? m_tgp : (k == 1) ? m_tsp : (k == 2) ? m_prev : {$urandom, $urandom};
        if ($urandom % 2 == 0) d[$urandom % 64] = ~d[$urandom % 64];
        send($urandom % 8 != 0, d);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule